// File: doc/BRIEF.md
# Tournament Global/Local Branch Direction Predictor

This block predicts whether a conditional branch is taken. Two component predictors run side by side. The first is a table of 2-bit saturating counters indexed by a shift register that holds the outcomes of the most recent branches in the whole program. The second works per branch in two levels. A table of per-branch outcome histories, selected by address bits of the branch, gives a history value. That value then indexes a table of 3-bit saturating counters. A third table of 2-bit counters, indexed by the global outcome history, decides for each lookup which component's guess becomes the final prediction.

The fetch side presents a branch address on the lookup port. In the same cycle it receives the final direction together with both component guesses and the chooser's selection. When the branch resolves, the execute side presents the address, the real outcome, and the two component guesses recorded at lookup. On the following clock edge all tables train and both histories shift in the outcome. Target prediction and recovery of speculatively updated history are not part of this block.

Top module: `tour_bp`

## Requirements
- R1: After reset the global history and every per-branch history are zero. Every global and chooser counter holds 1 (weakly not taken, weakly global). Every local counter holds 3. Every lookup therefore returns not taken with use_local 0.
- R2: The global guess is the MSB of the 2-bit counter indexed by the 12-bit global history. On resolve, that counter steps up on taken and down on not taken, saturating at 0 and 3.
- R3: On resolve the global history shifts left by one and takes the actual outcome in bit 0. Bit i therefore records the (i+1)-th most recent resolved branch, with 1 meaning taken.
- R4: The per-branch history table has 1024 entries of 10 bits and is selected by PC bits [11:2]. On resolve the selected entry shifts left and takes the outcome in bit 0. Addresses that differ only outside bits [11:2] share an entry.
- R5: The local guess is taken when the 3-bit counter indexed by the selected 10-bit history is 4 or more. On resolve, the counter indexed by the resolving branch's history steps up on taken and down on not taken, saturating at 0 and 7.
- R6: The chooser counter is indexed by the global history. When its MSB is 1 the final prediction is the local guess, otherwise the global guess.
- R7: The chooser counter changes only when the recorded global and local guesses differ. It steps toward local (up) when the local guess matched the outcome and toward global (down) otherwise, saturating at 0 and 3.
- R8: With res_valid_i low no table and no history changes, so repeated lookups return the same results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pred_pc_i | input | 32 | Address of the branch being looked up |
| pred_taken_o | output | 1 | Final predicted direction, 1 = taken |
| pred_global_o | output | 1 | Global component guess |
| pred_local_o | output | 1 | Local component guess |
| pred_use_local_o | output | 1 | Chooser selection, 1 = local component |
| res_valid_i | input | 1 | A branch resolves this cycle |
| res_pc_i | input | 32 | Address of the resolving branch |
| res_taken_i | input | 1 | Actual outcome, 1 = taken |
| res_global_i | input | 1 | Global guess recorded at lookup |
| res_local_i | input | 1 | Local guess recorded at lookup |

## Verification
Some branches are always taken and others never taken. These saturate both counter types at their top and bottom limits and show whether the global history fills with ones or zeros. Branches that alternate or repeat a loop count of nine taken then one exit favour the per-branch component over the global one, so they separate a correct chooser from one that trains on agreement or in the wrong direction. Random mixes over a small address pool, including addresses that differ only above bit 11 and idle cycles without a resolve, expose wrong history indexing, aliasing and spurious updates.

// File: rtl/tour_pkg.sv
package tour_pkg;
  // saturating step for an n-bit counter held in 8 bits
  function automatic logic [7:0] sat_step(input logic [7:0] cur, input logic [7:0] max, input logic up);
    if (up) return (cur == max) ? cur : cur + 8'd1;
    else    return (cur == 8'd0) ? cur : cur - 8'd1;
  endfunction
endpackage

// File: rtl/tour_ctr_table.sv
module tour_ctr_table #(
  parameter int IDX_W = 12,
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_msb_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_up_i
);
  import tour_pkg::*;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CMAX  = '1;
  localparam logic [CNT_W-1:0] CINIT = CMAX >> 1;

  logic [CNT_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0] nxt;
  logic [7:0]       step;

  always_comb begin
    step = sat_step(8'(mem[wr_idx_i]), 8'(CMAX), wr_up_i);
    nxt  = step[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CINIT;
    end else if (wr_en_i) begin
      mem[wr_idx_i] <= nxt;
    end
  end

  assign rd_msb_o = mem[rd_idx_i][CNT_W-1];
endmodule

// File: rtl/tour_lhist.sv
module tour_lhist #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [HIST_W-1:0] rd_hist_o,
  input  logic [IDX_W-1:0]  res_idx_i,
  output logic [HIST_W-1:0] res_hist_o,
  input  logic              wr_en_i,
  input  logic              taken_i
);
  localparam int DEPTH = 1 << IDX_W;
  logic [HIST_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en_i) begin
      mem[res_idx_i] <= {mem[res_idx_i][HIST_W-2:0], taken_i};
    end
  end

  assign rd_hist_o  = mem[rd_idx_i];
  assign res_hist_o = mem[res_idx_i];
endmodule

// File: rtl/tour_ghist.sv
module tour_ghist #(
  parameter int HIST_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              taken_i,
  output logic [HIST_W-1:0] hist_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_o <= '0;
    else if (shift_i) hist_o <= {hist_o[HIST_W-2:0], taken_i};
  end
endmodule

// File: rtl/tour_bp.sv
module tour_bp #(
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter int GHIST_W   = 12,
  parameter int LHT_IDX_W = 10,
  parameter int LHIST_W   = 10,
  parameter int GCNT_W    = 2,
  parameter int LCNT_W    = 3,
  parameter int CH_CNT_W  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] pred_pc_i,
  output logic            pred_taken_o,
  output logic            pred_global_o,
  output logic            pred_local_o,
  output logic            pred_use_local_o,
  input  logic            res_valid_i,
  input  logic [PC_W-1:0] res_pc_i,
  input  logic            res_taken_i,
  input  logic            res_global_i,
  input  logic            res_local_i
);
  logic [GHIST_W-1:0]   ghist;
  logic [LHIST_W-1:0]   pred_lhist, res_lhist;
  logic [LHT_IDX_W-1:0] pred_lidx, res_lidx;
  logic                 disagree;

  assign pred_lidx = pred_pc_i[PC_LSB +: LHT_IDX_W];
  assign res_lidx  = res_pc_i[PC_LSB +: LHT_IDX_W];
  assign disagree  = res_global_i ^ res_local_i;

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pred_pc_i, res_pc_i};

  tour_ghist #(.HIST_W(GHIST_W)) u_ghist (
    .clk_i, .rst_ni, .shift_i(res_valid_i), .taken_i(res_taken_i), .hist_o(ghist)
  );

  tour_lhist #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lhist (
    .clk_i, .rst_ni,
    .rd_idx_i(pred_lidx), .rd_hist_o(pred_lhist),
    .res_idx_i(res_lidx), .res_hist_o(res_lhist),
    .wr_en_i(res_valid_i), .taken_i(res_taken_i)
  );

  tour_ctr_table #(.IDX_W(GHIST_W), .CNT_W(GCNT_W)) u_gtab (
    .clk_i, .rst_ni,
    .rd_idx_i(ghist), .rd_msb_o(pred_global_o),
    .wr_en_i(res_valid_i), .wr_idx_i(ghist), .wr_up_i(res_taken_i)
  );

  tour_ctr_table #(.IDX_W(LHIST_W), .CNT_W(LCNT_W)) u_ltab (
    .clk_i, .rst_ni,
    .rd_idx_i(pred_lhist), .rd_msb_o(pred_local_o),
    .wr_en_i(res_valid_i), .wr_idx_i(res_lhist), .wr_up_i(res_taken_i)
  );

  // chooser trains only on disagreement, up = toward local
  tour_ctr_table #(.IDX_W(GHIST_W), .CNT_W(CH_CNT_W)) u_choose (
    .clk_i, .rst_ni,
    .rd_idx_i(ghist), .rd_msb_o(pred_use_local_o),
    .wr_en_i(res_valid_i & disagree), .wr_idx_i(ghist),
    .wr_up_i(res_local_i == res_taken_i)
  );

  assign pred_taken_o = pred_use_local_o ? pred_local_o : pred_global_o;
endmodule

// File: rtl/tour_bp_chk.sv
module tour_bp_chk #(
  parameter int HIST_W = 12,
  parameter int PC_W   = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [HIST_W-1:0] ghist_i,
  input logic [PC_W-1:0]   pred_pc_i,
  input logic              pred_taken_o,
  input logic              pred_global_o,
  input logic              pred_local_o,
  input logic              pred_use_local_o,
  input logic              res_valid_i,
  input logic              res_taken_i
);
  assert_hist_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |=> ghist_i == {$past(ghist_i[HIST_W-2:0]), $past(res_taken_i)});

  assert_hist_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> $stable(ghist_i));

  assert_pred_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(res_valid_i) && $stable(pred_pc_i)) |-> ($stable(pred_taken_o) && $stable(pred_use_local_o)));

  assert_reset_hist_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> ghist_i == '0);

  always_comb begin
    if (rst_ni) begin
      assert_select_R6: assert (pred_taken_o == (pred_use_local_o ? pred_local_o : pred_global_o));
    end
  end
endmodule

bind tour_bp tour_bp_chk #(.HIST_W(GHIST_W), .PC_W(PC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ghist_i(ghist), .pred_pc_i(pred_pc_i),
  .pred_taken_o(pred_taken_o), .pred_global_o(pred_global_o),
  .pred_local_o(pred_local_o), .pred_use_local_o(pred_use_local_o),
  .res_valid_i(res_valid_i), .res_taken_i(res_taken_i)
);

// File: tb/sim_tour_bp.sv
module sim_tour_bp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        pred_taken, pred_global, pred_local, pred_use_local;
  logic        res_valid = 1'b0;
  logic [31:0] res_pc = '0;
  logic        res_taken = 1'b0, res_global = 1'b0, res_local = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tour_bp u0 (
    .clk_i(clk), .rst_ni(rst_n), .pred_pc_i(pred_pc),
    .pred_taken_o(pred_taken), .pred_global_o(pred_global),
    .pred_local_o(pred_local), .pred_use_local_o(pred_use_local),
    .res_valid_i(res_valid), .res_pc_i(res_pc), .res_taken_i(res_taken),
    .res_global_i(res_global), .res_local_i(res_local)
  );

  // reference state
  logic [1:0]  m_g [4096];
  logic [1:0]  m_c [4096];
  logic [2:0]  m_l [1024];
  logic [9:0]  m_h [1024];
  logic [11:0] m_gh;

  function automatic logic [2:0] step(input logic [2:0] v, input logic [2:0] max, input logic up);
    if (up) return (v == max) ? v : v + 3'd1;
    return (v == 3'd0) ? v : v - 3'd1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4096; i++) begin m_g[i] = 2'd1; m_c[i] = 2'd1; end
    for (int i = 0; i < 1024; i++) begin m_l[i] = 3'd3; m_h[i] = '0; end
    m_gh = '0;
  endtask

  task automatic model_update(input logic [31:0] pc, input logic t, input logic gp, input logic lp);
    logic [9:0] idx, h;
    logic [2:0] tmp;
    idx = pc[11:2];
    h = m_h[idx];
    tmp = step({1'b0, m_g[m_gh]}, 3'd3, t); m_g[m_gh] = tmp[1:0];
    m_l[h] = step(m_l[h], 3'd7, t);
    if (gp != lp) begin
      tmp = step({1'b0, m_c[m_gh]}, 3'd3, lp == t); m_c[m_gh] = tmp[1:0];
    end
    m_h[idx] = {h[8:0], t};
    m_gh = {m_gh[10:0], t};
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // one lookup, optionally followed by a resolve in the same cycle
  task automatic op(input logic [31:0] pc, input logic do_res, input logic t, input string tag);
    logic eg, el, eu, et;
    @(negedge clk);
    pred_pc = pc;
    res_valid = 1'b0;
    #1;
    eg = m_g[m_gh][1];
    el = m_l[m_h[pc[11:2]]][2];
    eu = m_c[m_gh][1];
    et = eu ? el : eg;
    chk({tag, " R2 global guess"}, pred_global, eg);
    chk({tag, " R4 R5 local guess"}, pred_local, el);
    chk({tag, " R6 R7 chooser"}, pred_use_local, eu);
    chk({tag, " R6 final"}, pred_taken, et);
    if (do_res) begin
      res_valid = 1'b1; res_pc = pc; res_taken = t;
      res_global = pred_global; res_local = pred_local;
      @(posedge clk);
      model_update(pc, t, res_global, res_local);
      #1 res_valid = 1'b0;
    end else begin
      @(posedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pool [8];
    int cnt [8];
    void'($urandom(32'h5eed_0042));
    model_reset();
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;

    // R1: reset state seen through lookups
    op(32'h0000_1000, 1'b0, 1'b0, "R1");
    op(32'h0000_2ffc, 1'b0, 1'b0, "R1");
    chk("R1 reset final not taken", pred_taken, 1'b0);

    // R2 R3: always taken saturates, then one not-taken
    for (int i = 0; i < 30; i++) op(32'h0000_0040, 1'b1, 1'b1, "R2 R3 all-taken");
    op(32'h0000_0040, 1'b1, 1'b0, "R2 R3 one-exit");
    for (int i = 0; i < 30; i++) op(32'h0000_0080, 1'b1, 1'b0, "R2 R5 never-taken");

    // R4 R5 R7: alternating and loop patterns
    for (int i = 0; i < 60; i++) op(32'h0000_0104, 1'b1, i[0], "R4 R7 alternate");
    for (int i = 0; i < 100; i++) op(32'h0000_0208, 1'b1, (i % 10) != 9, "R5 R7 loop");

    // R4: alias above bit 11 shares the per-branch entry
    op(32'h0001_0208, 1'b1, 1'b1, "R4 alias");
    op(32'h0000_0208, 1'b0, 1'b0, "R4 alias read");

    // R8: idle cycles, repeated lookups identical
    for (int i = 0; i < 6; i++) op(32'h0000_0104, 1'b0, 1'b1, "R8 idle");

    // random mix
    for (int k = 0; k < 8; k++) begin
      pool[k] = {$urandom} & 32'h0000_fffc;
      cnt[k] = 0;
    end
    pool[7] = pool[6] ^ 32'h0002_0000;
    for (int i = 0; i < 3000; i++) begin
      int k;
      logic t;
      k = int'($urandom % 8);
      case (k % 4)
        0: t = 1'b1;
        1: t = 1'b0;
        2: t = cnt[k][0];
        default: t = $urandom % 2 == 0;
      endcase
      cnt[k]++;
      if ($urandom % 5 == 0) op(pool[k], 1'b0, t, "R8 random idle");
      else op(pool[k], 1'b1, t, "R3 R5 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule